// File: doc/BRIEF.md
# Strided Space-to-Depth Input Folder

This block sits in front of a convolution engine and reshapes a shallow-channel image stream. Every Sh-by-Sw patch of input pixels becomes one output pixel. The output pixel carries C·Sh·Sw channels. The spatial size therefore shrinks by the stride of the first convolution, which raises channel utilisation in wide-vector compute arrays. Partial patches at the bottom and right edges are rounded up, and their missing positions are filled with zero. A bypass setting forwards the stream untouched, which helps when debugging.

Both streams carry one channel element per beat and use valid/ready flow control. Pixels arrive in raster order with the channel index varying fastest. A transfer happens on a rising clock edge when valid and ready are both high. A source that raises valid keeps its data and flags steady until the transfer. The block follows the same rule on its output, so it holds out_data, out_sof and out_eol steady while out_ready is low. A frame starts with a beat that carries the start-of-frame flag. At that beat the block samples the bypass setting, both strides and the dimensions H, W and C. In folding mode it collects Sh input rows in a line memory and then drains one output row. No input is accepted while it drains.

Top module: `s2d_fold`

## Requirements
- R1: With cfg_bypass high at the start-of-frame beat, the frame's H·W·C beats appear on the output unchanged and in order, with in_sof and in_eol forwarded as given. In this mode in_ready follows out_ready.
- R2: In folding mode, each output pixel is C·Sh·Sw beats. Output channel (dy·Sw+dx)·C+c carries input channel c of pixel (oy·Sh+dy, ox·Sw+dx).
- R3: A folded frame has ceil(H/Sh) rows of ceil(W/Sw) output pixels. out_sof is high only on the frame's first output beat, and out_eol only on the last beat of each output row.
- R4: Patch positions that fall outside the H×W input carry data 0.
- R5: Folding with Sh = Sw = 1 reproduces the input data in input order, with one out_eol per input row.
- R6: Settings are sampled at the start-of-frame beat, and later changes have no effect on that frame. A stride programmed as 0 is taken as 1, and one above 4 is taken as 4.
- R7: While out_valid is high and out_ready is low, out_valid, out_data, out_sof and out_eol stay unchanged. No beat is lost or repeated.
- R8: Between frames nothing is emitted. Input beats without the start-of-frame flag are accepted and discarded.
- R9: In folding mode, frame and row boundaries come from the sampled H, W and C, and in_eol is ignored. The block accepts no input while it drains an output row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | 1 = forward the stream unchanged |
| cfg_sh | input | SB | Vertical stride (1..MAX_S) |
| cfg_sw | input | SB | Horizontal stride (1..MAX_S) |
| cfg_h | input | HB | Input height in rows |
| cfg_w | input | WB | Input width in pixels (1..MAX_W) |
| cfg_c | input | CB | Channels per input pixel (1..MAX_C) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts the input beat |
| in_data | input | DW | Input channel element |
| in_sof | input | 1 | First beat of a frame |
| in_eol | input | 1 | Last beat of an input row (used in bypass only) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | DW | Output channel element |
| out_sof | output | 1 | First beat of the output frame |
| out_eol | output | 1 | Last beat of an output row |

## Verification
A wrong patch counter or a wrong line-memory index shows up as a data mismatch on the first beat that reads the wrong location. Most frames are only a few patches wide, so this happens within one output pixel of the fault. A wrong row or column limit moves out_eol, or changes the number of beats in a frame. The scoreboard then sees a misplaced flag or a leftover or extra beat at the end of that frame. A wrong zero-fill decision puts a stored value where 0 is expected, or the reverse, on the first edge patch. Odd sizes with strides of 2, 3 and 4 place such patches in every frame.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_PASS  = 2'd1,
    F_FILL  = 2'd2,
    F_DRAIN = 2'd3
  } fold_st_e;
endpackage

// File: rtl/s2d_fold_linebuf.sv
// Line memory: MAX_S rows of MAX_W pixels of MAX_C channel elements.
module s2d_fold_linebuf #(
  parameter int DW    = 8,
  parameter int MAX_W = 16,
  parameter int MAX_C = 4,
  parameter int MAX_S = 4,
  parameter int SB    = 3,
  parameter int WB    = 5,
  parameter int CB    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [SB-1:0] wr_row,
  input  logic [WB-1:0] wr_x,
  input  logic [CB-1:0] wr_c,
  input  logic [DW-1:0] wr_data,
  input  logic [SB-1:0] rd_row,
  input  logic [WB-1:0] rd_x,
  input  logic [CB-1:0] rd_c,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = MAX_S * MAX_W * MAX_C;
  localparam int AB    = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AB-1:0] wa, ra;

  assign wa = AB'(int'(wr_row) * MAX_W * MAX_C + int'(wr_x) * MAX_C + int'(wr_c));
  assign ra = AB'(int'(rd_row) * MAX_W * MAX_C + int'(rd_x) * MAX_C + int'(rd_c));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  assign rd_data = mem[ra];
endmodule

// File: rtl/s2d_fold_ctrl.sv
// Frame sequencer: samples settings, counts input positions, walks the patches.
module s2d_fold_ctrl
  import fold_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int MAX_C = 4,
  parameter int MAX_S = 4,
  parameter int HB    = 8,
  parameter int SB    = 3,
  parameter int WB    = 5,
  parameter int CB    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bypass,
  input  logic [SB-1:0] cfg_sh,
  input  logic [SB-1:0] cfg_sw,
  input  logic [HB-1:0] cfg_h,
  input  logic [WB-1:0] cfg_w,
  input  logic [CB-1:0] cfg_c,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          in_ready,
  input  logic          out_ready,
  output logic          wr_en,
  output logic [SB-1:0] wr_row,
  output logic [WB-1:0] wr_x,
  output logic [CB-1:0] wr_c,
  output logic [SB-1:0] rd_row,
  output logic [WB-1:0] rd_x,
  output logic [CB-1:0] rd_c,
  output logic          rd_pad,
  output logic          drain_valid,
  output logic          fold_sof,
  output logic          fold_eol,
  output logic          byp,
  output fold_st_e      st,
  output logic [SB-1:0] sh_o,
  output logic [WB-1:0] w_o
);
  localparam int XW = WB + 1;
  localparam logic [SB-1:0] SMAX = SB'(MAX_S);
  localparam logic [WB-1:0] WMAX = WB'(MAX_W);
  localparam logic [CB-1:0] CMAX = CB'(MAX_C);

  fold_st_e      st_q;
  logic          lbyp;
  logic [SB-1:0] lsh, lsw;
  logic [HB-1:0] lh;
  logic [WB-1:0] lw;
  logic [CB-1:0] lc;
  // input position
  logic [WB-1:0] x_q;
  logic [CB-1:0] c_q;
  logic [SB-1:0] dy_q;
  logic [HB-1:0] row_q;
  // drain position
  logic [XW-1:0] xb_q;
  logic [SB-1:0] ddy_q, ddx_q, got_q;
  logic [CB-1:0] dc_q;
  logic          last_q, first_q;

  // clamped settings
  logic [SB-1:0] n_sh, n_sw;
  logic [HB-1:0] n_h;
  logic [WB-1:0] n_w;
  logic [CB-1:0] n_c;
  always_comb begin
    n_sh = (cfg_sh == '0) ? SB'(1) : (cfg_sh > SMAX) ? SMAX : cfg_sh;
    n_sw = (cfg_sw == '0) ? SB'(1) : (cfg_sw > SMAX) ? SMAX : cfg_sw;
    n_h  = (cfg_h  == '0) ? HB'(1) : cfg_h;
    n_w  = (cfg_w  == '0) ? WB'(1) : (cfg_w > WMAX) ? WMAX : cfg_w;
    n_c  = (cfg_c  == '0) ? CB'(1) : (cfg_c > CMAX) ? CMAX : cfg_c;
  end

  logic accept, c_end, row_end, last_row;
  logic dc_end, dx_end, dy_end, ox_end;
  logic [XW-1:0] rx;

  always_comb begin
    unique case (st_q)
      F_IDLE:  in_ready = !in_sof;
      F_PASS:  in_ready = out_ready;
      F_FILL:  in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign accept   = in_valid && in_ready && (st_q == F_PASS || st_q == F_FILL);
  assign c_end    = (c_q == lc - 1'b1);
  assign row_end  = c_end && (x_q == lw - 1'b1);
  assign last_row = (row_q == lh - 1'b1);

  assign dc_end = (dc_q == lc - 1'b1);
  assign dx_end = (ddx_q == lsw - 1'b1);
  assign dy_end = (ddy_q == lsh - 1'b1);
  assign ox_end = (xb_q + XW'(lsw)) >= XW'(lw);
  assign rx     = xb_q + XW'(ddx_q);

  assign wr_en       = accept && (st_q == F_FILL);
  assign wr_row      = dy_q;
  assign wr_x        = x_q;
  assign wr_c        = c_q;
  assign rd_row      = ddy_q;
  assign rd_x        = rx[WB-1:0];
  assign rd_c        = dc_q;
  assign rd_pad      = (ddy_q >= got_q) || (rx >= XW'(lw));
  assign drain_valid = (st_q == F_DRAIN);
  assign fold_eol    = dc_end && dx_end && dy_end && ox_end;
  assign fold_sof    = first_q && (xb_q == '0) && (ddy_q == '0) && (ddx_q == '0) && (dc_q == '0);
  assign byp         = (st_q == F_PASS);
  assign st          = st_q;
  assign sh_o        = lsh;
  assign w_o         = lw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= F_IDLE;
      lbyp <= 1'b0;
      lsh <= SB'(1); lsw <= SB'(1);
      lh <= HB'(1); lw <= WB'(1); lc <= CB'(1);
      x_q <= '0; c_q <= '0; dy_q <= '0; row_q <= '0;
      xb_q <= '0; ddy_q <= '0; ddx_q <= '0; dc_q <= '0; got_q <= '0;
      last_q <= 1'b0; first_q <= 1'b0;
    end else begin
      unique case (st_q)
        F_IDLE: if (in_valid && in_sof) begin
          lbyp <= cfg_bypass;
          lsh <= n_sh; lsw <= n_sw; lh <= n_h; lw <= n_w; lc <= n_c;
          x_q <= '0; c_q <= '0; dy_q <= '0; row_q <= '0;
          first_q <= 1'b1;
          st_q <= cfg_bypass ? F_PASS : F_FILL;
        end
        F_PASS, F_FILL: if (accept) begin
          if (c_end) begin
            c_q <= '0;
            x_q <= (x_q == lw - 1'b1) ? '0 : x_q + 1'b1;
          end else begin
            c_q <= c_q + 1'b1;
          end
          if (row_end) begin
            row_q <= row_q + 1'b1;
            dy_q  <= dy_q + 1'b1;
            if (st_q == F_PASS) begin
              if (last_row) st_q <= F_IDLE;
            end else if (dy_q == lsh - 1'b1 || last_row) begin
              st_q   <= F_DRAIN;
              got_q  <= dy_q + 1'b1;
              last_q <= last_row;
              dy_q   <= '0;
              xb_q <= '0; ddy_q <= '0; ddx_q <= '0; dc_q <= '0;
            end
          end
        end
        F_DRAIN: if (out_ready) begin
          if (!dc_end) begin
            dc_q <= dc_q + 1'b1;
          end else begin
            dc_q <= '0;
            if (!dx_end) begin
              ddx_q <= ddx_q + 1'b1;
            end else begin
              ddx_q <= '0;
              if (!dy_end) begin
                ddy_q <= ddy_q + 1'b1;
              end else begin
                ddy_q <= '0;
                if (!ox_end) begin
                  xb_q <= xb_q + XW'(lsw);
                end else begin
                  xb_q    <= '0;
                  first_q <= 1'b0;
                  st_q    <= last_q ? F_IDLE : F_FILL;
                end
              end
            end
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = lbyp;
endmodule

// File: rtl/s2d_fold_outmux.sv
// Output selection: bypass forwarding, stored element or zero fill.
module s2d_fold_outmux #(
  parameter int DW = 8
) (
  input  logic          byp,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic          drain_valid,
  input  logic          rd_pad,
  input  logic [DW-1:0] rd_data,
  input  logic          fold_sof,
  input  logic          fold_eol,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol
);
  always_comb begin
    if (byp) begin
      out_valid = in_valid;
      out_data  = in_data;
      out_sof   = in_sof;
      out_eol   = in_eol;
    end else begin
      out_valid = drain_valid;
      out_data  = rd_pad ? '0 : rd_data;
      out_sof   = drain_valid && fold_sof;
      out_eol   = drain_valid && fold_eol;
    end
  end
endmodule

// File: rtl/s2d_fold.sv
module s2d_fold
  import fold_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MAX_W = 16,
  parameter int MAX_C = 4,
  parameter int MAX_S = 4,
  parameter int HB    = 8,
  localparam int SB   = $clog2(MAX_S + 1),
  localparam int WB   = $clog2(MAX_W + 1),
  localparam int CB   = $clog2(MAX_C + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_bypass,
  input  logic [SB-1:0] cfg_sh,
  input  logic [SB-1:0] cfg_sw,
  input  logic [HB-1:0] cfg_h,
  input  logic [WB-1:0] cfg_w,
  input  logic [CB-1:0] cfg_c,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol
);
  logic          wr_en, rd_pad, drain_valid, fold_sof, fold_eol, byp;
  logic [SB-1:0] wr_row, rd_row, sh_o;
  logic [WB-1:0] wr_x, rd_x, w_o;
  logic [CB-1:0] wr_c, rd_c;
  logic [DW-1:0] rd_data;
  fold_st_e      st;

  s2d_fold_ctrl #(
    .MAX_W(MAX_W), .MAX_C(MAX_C), .MAX_S(MAX_S),
    .HB(HB), .SB(SB), .WB(WB), .CB(CB)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_bypass(cfg_bypass), .cfg_sh(cfg_sh), .cfg_sw(cfg_sw),
    .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_c(cfg_c),
    .in_valid(in_valid), .in_sof(in_sof), .in_ready(in_ready),
    .out_ready(out_ready),
    .wr_en(wr_en), .wr_row(wr_row), .wr_x(wr_x), .wr_c(wr_c),
    .rd_row(rd_row), .rd_x(rd_x), .rd_c(rd_c), .rd_pad(rd_pad),
    .drain_valid(drain_valid), .fold_sof(fold_sof), .fold_eol(fold_eol),
    .byp(byp), .st(st), .sh_o(sh_o), .w_o(w_o)
  );

  s2d_fold_linebuf #(
    .DW(DW), .MAX_W(MAX_W), .MAX_C(MAX_C), .MAX_S(MAX_S),
    .SB(SB), .WB(WB), .CB(CB)
  ) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_x(wr_x), .wr_c(wr_c),
    .wr_data(in_data), .rd_row(rd_row), .rd_x(rd_x), .rd_c(rd_c),
    .rd_data(rd_data)
  );

  s2d_fold_outmux #(.DW(DW)) u_mux (
    .byp(byp), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol),
    .drain_valid(drain_valid), .rd_pad(rd_pad), .rd_data(rd_data),
    .fold_sof(fold_sof), .fold_eol(fold_eol),
    .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol)
  );
endmodule

// File: rtl/s2d_fold_chk.sv
module s2d_fold_chk
  import fold_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MAX_S = 4,
  parameter int SB    = 3,
  parameter int WB    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input fold_st_e      st,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sof,
  input logic          out_eol,
  input logic [SB-1:0] sh_o,
  input logic [WB-1:0] w_o
);
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)));

  // R9
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_DRAIN) |-> !in_ready);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != F_IDLE && $past(st) != F_IDLE) |-> ($stable(sh_o) && $stable(w_o)));

  // R6
  stride_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != F_IDLE) |-> (sh_o >= SB'(1) && sh_o <= SB'(MAX_S)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_IDLE) |-> !out_valid);
endmodule

bind s2d_fold s2d_fold_chk #(.DW(DW), .MAX_S(MAX_S), .SB(SB), .WB(WB)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eol(out_eol), .sh_o(sh_o), .w_o(w_o)
);

// File: tb/s2d_fold_test.sv
module s2d_fold_test;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_bypass = 1'b0;
  logic [2:0] cfg_sh = 3'd1, cfg_sw = 3'd1;
  logic [7:0] cfg_h = 8'd1;
  logic [4:0] cfg_w = 5'd1;
  logic [2:0] cfg_c = 3'd1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0;
  logic [DW+1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  s2d_fold uut (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_sh(cfg_sh),
    .cfg_sw(cfg_sw), .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_c(cfg_c),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol)
  );

  function automatic logic [DW-1:0] pix(int fid, int y, int x, int c, int w, int nc);
    return DW'(((fid * 37 + (y * w + x) * nc + c) % 255) + 1);
  endfunction

  function automatic int clampS(int s);
    return (s == 0) ? 1 : (s > 4) ? 4 : s;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: sets ready at the falling edge, samples the upcoming transfer 2 units later
  logic [DW+1:0] held;
  bit held_v = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 3) != 0;
      #2;
      if (rst_n) begin
        if (held_v && out_valid)
          check({out_sof, out_eol, out_data} == held, "R7", "held beat changed",
                int'({out_sof, out_eol, out_data}), int'(held));
        else if (held_v)
          check(1'b0, "R7", "valid dropped under stall", 0, 1);
        held_v = out_valid && !out_ready;
        held   = {out_sof, out_eol, out_data};
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected output beat", int'(out_data), -1);
          end else begin
            logic [DW+1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_sof, out_eol, out_data} == e, t, "beat {sof,eol,data}",
                  int'({out_sof, out_eol, out_data}), int'(e));
          end
        end
      end
    end
  end

  task automatic push_beat(bit s, bit e, logic [DW-1:0] d, string t);
    exp_q.push_back({s, e, d});
    tag_q.push_back(t);
  endtask

  task automatic drive_beat(bit s, bit e, logic [DW-1:0] d);
    @(negedge clk);
    while (($urandom % 4) == 0) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1; in_sof = s; in_eol = e; in_data = d;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(int fid, int h, int w, int nc, int sh, int sw,
                            bit byp, bit noeol, string t);
    int s1, s2, oh, ow;
    s1 = clampS(sh); s2 = clampS(sw);
    if (byp) begin
      for (int y = 0; y < h; y++)
        for (int x = 0; x < w; x++)
          for (int c = 0; c < nc; c++)
            push_beat(y == 0 && x == 0 && c == 0, !noeol && x == w-1 && c == nc-1,
                      pix(fid, y, x, c, w, nc), t);
    end else begin
      oh = (h + s1 - 1) / s1; ow = (w + s2 - 1) / s2;
      for (int oy = 0; oy < oh; oy++)
        for (int ox = 0; ox < ow; ox++)
          for (int dy = 0; dy < s1; dy++)
            for (int dx = 0; dx < s2; dx++)
              for (int c = 0; c < nc; c++) begin
                int yy, xx;
                yy = oy * s1 + dy; xx = ox * s2 + dx;
                push_beat(oy == 0 && ox == 0 && dy == 0 && dx == 0 && c == 0,
                          ox == ow-1 && dy == s1-1 && dx == s2-1 && c == nc-1,
                          (yy < h && xx < w) ? pix(fid, yy, xx, c, w, nc) : '0, t);
              end
    end
    cfg_bypass = byp; cfg_sh = 3'(sh); cfg_sw = 3'(sw);
    cfg_h = 8'(h); cfg_w = 5'(w); cfg_c = 3'(nc);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++)
        for (int c = 0; c < nc; c++) begin
          drive_beat(y == 0 && x == 0 && c == 0, !noeol && x == w-1 && c == nc-1,
                     pix(fid, y, x, c, w, nc));
          // R6: scramble settings once the frame has started
          cfg_bypass = !byp; cfg_sh = 3'd3; cfg_sw = 3'd1;
          cfg_h = 8'd2; cfg_w = 5'd7; cfg_c = 3'd2;
        end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic stray(int n);
    for (int i = 0; i < n; i++) drive_beat(1'b0, 1'b0, DW'(8'hA5));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R8", "reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "reset in_ready", int'(in_ready), 1);

    send_frame(1, 5, 5, 1, 2, 2, 1'b0, 1'b0, "R2/R3/R4 5x5 s2x2");
    send_frame(2, 3, 4, 3, 2, 2, 1'b1, 1'b0, "R1 bypass");
    send_frame(3, 4, 5, 2, 3, 2, 1'b0, 1'b0, "R2/R4 s3x2 c2");
    send_frame(4, 3, 3, 2, 1, 1, 1'b0, 1'b0, "R5 s1x1");
    stray(3);
    send_frame(5, 4, 4, 1, 4, 4, 1'b0, 1'b0, "R8 after stray, s4x4");
    send_frame(6, 2, 3, 1, 0, 2, 1'b0, 1'b0, "R6 stride0->1");
    send_frame(7, 3, 3, 1, 6, 2, 1'b0, 1'b0, "R6 stride6->4");
    send_frame(8, 1, 16, 4, 2, 2, 1'b0, 1'b1, "R9 no eol, max W/C");
    send_frame(9, 2, 2, 2, 1, 1, 1'b1, 1'b0, "R1 bypass short");

    check(exp_q.size() == 0, "R3", "leftover expected beats", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule